// File: doc/BRIEF.md
# Multi-Mode Streaming Pooling Unit

This block reduces one channel of an image as it streams past. Pixels arrive in raster order over a valid/ready input. For each frame the block emits pooled pixels in raster order over a valid/ready output. A start pulse captures the frame geometry, given as width minus one and height minus one. The same pulse captures a 4-bit mode code that selects the pooling rule. The supported rules are pass-through, signed maximum, floored mean, and corner selection. They work over non-overlapping 2x2 or 4x4 tiles, and also over overlapping 2x2 windows that step one pixel at a time.

The block does not keep raw rows for the tiled modes. It folds each tile as the pixels arrive: a horizontal partial result sits in a register, and a column store keeps one partial result per output column. The overlapping modes keep one raw row of the image. A single output register absorbs backpressure. After the last result of a frame has been taken, the block raises a one-cycle completion pulse.

Top module: `pool_unit`

## Requirements
- R1: Mode 0 passes each input pixel to the output unchanged, one output per input, in the same order.
- R2: Modes 1 (2x2 tiles), 3 (4x4 tiles) and 9 (overlapping 2x2, step 1) output the largest pixel of the window. Pixels are compared as 16-bit two's-complement values.
- R3: Modes 2 (2x2 tiles), 4 (4x4 tiles) and 8 (overlapping 2x2, step 1) output the sum of the window divided by its pixel count (4 or 16), rounded toward negative infinity.
- R4: Mode 5 outputs the top-left pixel of each 2x2 tile. Mode 6 outputs the top-right pixel of each 2x2 tile. Mode 7 outputs the top-left pixel of each 4x4 tile.
- R5: For a W x H frame with tile size s, the output has floor(W/s) x floor(H/s) pixels, and incomplete tiles at the right and bottom edges are dropped. The step-1 modes output (W-1) x (H-1) pixels. Outputs come in raster order.
- R6: Width minus one (10 bits) and height minus one (9 bits) are captured at the start pulse. Changing these inputs, or the mode input, while a frame is in progress has no effect on that frame.
- R7: Mode codes 10 to 15 behave as mode 0 and set an error flag. The flag stays set until reset, including across later frames with valid modes.
- R8: While the output is valid and not accepted, the output data holds steady. No result is lost or duplicated under any pattern of input gaps and output stalls.
- R9: After the last output of a frame has been accepted, `done` is high for exactly one cycle, with the output empty and input not ready. A frame that produces no output still ends with this pulse.
- R10: After reset, the output is not valid, the input is not ready, `done` is low and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame and captures the configuration (when idle) |
| cfgMode | input | 4 | Pooling mode code |
| cfgRowWidthM1 | input | 10 | Frame width minus one |
| cfgColHeightM1 | input | 9 | Frame height minus one |
| inValid | input | 1 | Input pixel present |
| inData | input | 16 | Input pixel, signed |
| inReady | output | 1 | Block accepts an input pixel this cycle |
| outValid | output | 1 | Output pixel present |
| outData | output | 16 | Pooled pixel, signed |
| outReady | input | 1 | Consumer accepts the output pixel |
| done | output | 1 | One-cycle pulse at the end of a frame |
| modeErr | output | 1 | Sticky flag for an unsupported mode code |

## Verification
Two things can fall in the same clock: the consumer takes the held result, and a new input pixel completes a window and reloads that same register. The bench provokes this by keeping `outReady` high for long stretches while input pixels arrive back to back, and by mixing in random stalls on both sides. A behavioural model builds the expected result list from the frame. Every clock, the bench checks each accepted output against the head of that list and checks that a stalled output has not moved. A lost, doubled or early result therefore shows up as a miscompare or as a count mismatch at `done`.

// File: rtl/pool_pkg.sv
package pool_pkg;

  typedef enum logic [1:0] {
    OP_MAX    = 2'd0,
    OP_SUM    = 2'd1,
    OP_PICK_L = 2'd2,
    OP_PICK_R = 2'd3
  } poolOp_e;

  typedef struct packed {
    logic [1:0] strideLog;  // 0 -> 1, 1 -> 2, 2 -> 4
    poolOp_e    op;
    logic       overlap;    // 2x2 window stepping by one pixel
  } modeCfg_t;

  typedef struct packed {
    logic take;     // pixel accepted this cycle
    logic emit;     // this pixel completes a window
    logic lxFirst;  // first column of a tile
    logic lxLast;   // last column of a tile
    logic lyFirst;  // first row of a tile
  } poolStrobe_t;

  function automatic logic modeIsBad(input logic [3:0] code);
    return code > 4'd9;
  endfunction

  function automatic modeCfg_t decodeMode(input logic [3:0] code);
    modeCfg_t m;
    m = '{strideLog: 2'd0, op: OP_PICK_L, overlap: 1'b0};
    case (code)
      4'd1: m = '{strideLog: 2'd1, op: OP_MAX,    overlap: 1'b0};
      4'd2: m = '{strideLog: 2'd1, op: OP_SUM,    overlap: 1'b0};
      4'd3: m = '{strideLog: 2'd2, op: OP_MAX,    overlap: 1'b0};
      4'd4: m = '{strideLog: 2'd2, op: OP_SUM,    overlap: 1'b0};
      4'd5: m = '{strideLog: 2'd1, op: OP_PICK_L, overlap: 1'b0};
      4'd6: m = '{strideLog: 2'd1, op: OP_PICK_R, overlap: 1'b0};
      4'd7: m = '{strideLog: 2'd2, op: OP_PICK_L, overlap: 1'b0};
      4'd8: m = '{strideLog: 2'd0, op: OP_SUM,    overlap: 1'b1};
      4'd9: m = '{strideLog: 2'd0, op: OP_MAX,    overlap: 1'b1};
      default: ;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pool_ctrl.sv
module pool_ctrl
  import pool_pkg::*;
#(
  parameter int ROW_BITS = 10,
  parameter int COL_BITS = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [3:0]          cfgMode,
  input  logic [ROW_BITS-1:0] cfgRowWidthM1,
  input  logic [COL_BITS-1:0] cfgColHeightM1,
  input  logic                inValid,
  output logic                inReady,
  input  logic                outValid,
  input  logic                outReady,
  output logic                done,
  output logic                modeErr,
  output modeCfg_t            modeR,
  output logic [ROW_BITS-1:0] colPos,
  output poolStrobe_t         strobes
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctrlState_e;

  ctrlState_e          state;
  logic [ROW_BITS-1:0] wM1;
  logic [COL_BITS-1:0] hM1;
  logic [ROW_BITS-1:0] xPos;
  logic [COL_BITS-1:0] yPos;
  logic [1:0]          lx, ly;
  logic [1:0]          tileMask;
  logic                lxLast, lyLast, lastPix, take, winDone;

  always_comb begin
    case (modeR.strideLog)
      2'd1:    tileMask = 2'd1;
      2'd2:    tileMask = 2'd3;
      default: tileMask = 2'd0;
    endcase
  end

  assign lxLast  = (lx == tileMask);
  assign lyLast  = (ly == tileMask);
  assign lastPix = (xPos == wM1) && (yPos == hM1);
  assign inReady = (state == ST_RUN) && (!outValid || outReady);
  assign take    = inValid && inReady;
  assign winDone = modeR.overlap ? ((xPos != '0) && (yPos != '0)) : (lxLast && lyLast);

  assign strobes = '{take: take, emit: take && winDone, lxFirst: (lx == 2'd0),
                     lxLast: lxLast, lyFirst: (ly == 2'd0)};
  assign colPos  = xPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wM1     <= '0;
      hM1     <= '0;
      xPos    <= '0;
      yPos    <= '0;
      lx      <= '0;
      ly      <= '0;
      modeR   <= '{strideLog: 2'd0, op: OP_PICK_L, overlap: 1'b0};
      modeErr <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            wM1   <= cfgRowWidthM1;
            hM1   <= cfgColHeightM1;
            modeR <= decodeMode(cfgMode);
            if (modeIsBad(cfgMode)) modeErr <= 1'b1;
            xPos  <= '0;
            yPos  <= '0;
            lx    <= '0;
            ly    <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (take) begin
            if (lastPix) begin
              state <= ST_DRAIN;
            end else if (xPos == wM1) begin
              xPos <= '0;
              lx   <= '0;
              yPos <= yPos + 1'b1;
              ly   <= lyLast ? 2'd0 : ly + 2'd1;
            end else begin
              xPos <= xPos + 1'b1;
              lx   <= lxLast ? 2'd0 : lx + 2'd1;
            end
          end
        end
        ST_DRAIN: begin
          if (!outValid) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: completion only once the output register has emptied
  p_done_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!outValid && !inReady));

  // R7: the error flag never clears outside reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);

  // R6: position stays inside the captured geometry
  p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> ((xPos <= wM1) && (yPos <= hM1)));

endmodule

// File: rtl/pool_datapath.sv
module pool_datapath
  import pool_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int ROW_BITS = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  poolStrobe_t             strobes,
  input  modeCfg_t                modeR,
  input  logic [ROW_BITS-1:0]     colPos,
  input  logic signed [PIX_W-1:0] inData,
  input  logic                    outReady,
  output logic                    outValid,
  output logic signed [PIX_W-1:0] outData
);

  localparam int MAX_COLS = 1 << ROW_BITS;
  localparam int ACC_W    = PIX_W + 4;

  logic signed [PIX_W-1:0] prevRow [MAX_COLS];
  logic signed [ACC_W-1:0] colAcc  [MAX_COLS];

  logic signed [ACC_W-1:0] hAcc, upLeft, curLeft;
  logic signed [ACC_W-1:0] pixExt, upPix, hNew, vOld, vNew, tileVal;
  logic signed [ACC_W-1:0] sum4, maxA, maxB, max4, lapVal, result;
  logic [ROW_BITS-1:0]     accIdx;

  function automatic logic signed [ACC_W-1:0] smax(input logic signed [ACC_W-1:0] a,
                                                   input logic signed [ACC_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign pixExt = ACC_W'(inData);
  assign accIdx = colPos >> modeR.strideLog;
  assign vOld   = colAcc[accIdx];
  assign upPix  = ACC_W'(prevRow[colPos]);

  // horizontal fold inside a tile row
  always_comb begin
    case (modeR.op)
      OP_MAX:    hNew = strobes.lxFirst ? pixExt : smax(hAcc, pixExt);
      OP_SUM:    hNew = strobes.lxFirst ? pixExt : hAcc + pixExt;
      OP_PICK_L: hNew = strobes.lxFirst ? pixExt : hAcc;
      default:   hNew = pixExt;
    endcase
  end

  // vertical fold across tile rows
  always_comb begin
    if (strobes.lyFirst) begin
      vNew = hNew;
    end else begin
      case (modeR.op)
        OP_MAX:  vNew = smax(vOld, hNew);
        OP_SUM:  vNew = vOld + hNew;
        default: vNew = vOld;
      endcase
    end
  end

  assign tileVal = (modeR.op == OP_SUM) ? (vNew >>> {modeR.strideLog, 1'b0}) : vNew;

  // overlapping 2x2 window
  assign sum4   = upLeft + upPix + curLeft + pixExt;
  assign maxA   = smax(upLeft, upPix);
  assign maxB   = smax(curLeft, pixExt);
  assign max4   = smax(maxA, maxB);
  assign lapVal = (modeR.op == OP_SUM) ? (sum4 >>> 2) : max4;
  assign result = modeR.overlap ? lapVal : tileVal;

  always_ff @(posedge clk) begin
    if (strobes.take) begin
      prevRow[colPos] <= inData;
      if (strobes.lxLast) colAcc[accIdx] <= vNew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hAcc    <= '0;
      upLeft  <= '0;
      curLeft <= '0;
    end else if (strobes.take) begin
      hAcc    <= hNew;
      upLeft  <= upPix;
      curLeft <= pixExt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strobes.emit) begin
      outValid <= 1'b1;
      outData  <= PIX_W'(result);
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R8: a stalled result stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8: a new result never overwrites one not yet taken
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emit |-> (!outValid || outReady));

endmodule

// File: rtl/pool_unit.sv
module pool_unit
  import pool_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int ROW_BITS = 10,
  parameter int COL_BITS = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [3:0]              cfgMode,
  input  logic [ROW_BITS-1:0]     cfgRowWidthM1,
  input  logic [COL_BITS-1:0]     cfgColHeightM1,
  input  logic                    inValid,
  input  logic signed [PIX_W-1:0] inData,
  output logic                    inReady,
  output logic                    outValid,
  output logic signed [PIX_W-1:0] outData,
  input  logic                    outReady,
  output logic                    done,
  output logic                    modeErr
);

  modeCfg_t            modeR;
  poolStrobe_t         strobes;
  logic [ROW_BITS-1:0] colPos;

  pool_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode),
    .cfgRowWidthM1(cfgRowWidthM1), .cfgColHeightM1(cfgColHeightM1),
    .inValid(inValid), .inReady(inReady), .outValid(outValid),
    .outReady(outReady), .done(done), .modeErr(modeErr),
    .modeR(modeR), .colPos(colPos), .strobes(strobes)
  );

  pool_datapath #(.PIX_W(PIX_W), .ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeR(modeR),
    .colPos(colPos), .inData(inData), .outReady(outReady),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: tb/pool_unit_bench.sv
module pool_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfgMode = '0;
  logic [9:0]  cfgRowWidthM1 = '0;
  logic [8:0]  cfgColHeightM1 = '0;
  logic        inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic        inReady, outValid, done, modeErr;
  logic signed [15:0] outData;
  logic        outReady = 1'b0;

  int vectors = 0;
  int misses  = 0;
  int img [0:4095];
  int expQ [$];

  always #5 clk = ~clk;

  pool_unit u_pool_unit (
    .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode),
    .cfgRowWidthM1(cfgRowWidthM1), .cfgColHeightM1(cfgColHeightM1),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .done(done), .modeErr(modeErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int floorDiv(input int a, input int d);
    int q = a / d;
    if ((a % d != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic string reqOf(input int mode);
    case (mode)
      1, 3, 9: return "R2";
      2, 4, 8: return "R3";
      5, 6, 7: return "R4";
      0:       return "R1";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference: list of expected outputs in raster order
  task automatic buildExpected(input int mode, input int w, input int h);
    int s;
    expQ.delete();
    s = (mode == 1 || mode == 2 || mode == 5 || mode == 6) ? 2 :
        (mode == 3 || mode == 4 || mode == 7) ? 4 : 1;
    if (mode == 8 || mode == 9) begin
      for (int oy = 1; oy < h; oy++)
        for (int ox = 1; ox < w; ox++) begin
          int a = img[(oy-1)*w + ox-1], b = img[(oy-1)*w + ox];
          int c = img[oy*w + ox-1],     d = img[oy*w + ox];
          if (mode == 8) expQ.push_back(floorDiv(a + b + c + d, 4));
          else begin
            int m = a;
            if (b > m) m = b;
            if (c > m) m = c;
            if (d > m) m = d;
            expQ.push_back(m);
          end
        end
    end else if (s == 1) begin
      for (int i = 0; i < w*h; i++) expQ.push_back(img[i]);
    end else begin
      for (int oy = 0; oy < h / s; oy++)
        for (int ox = 0; ox < w / s; ox++) begin
          int sum = 0;
          int mx = -100000;
          for (int ky = 0; ky < s; ky++)
            for (int kx = 0; kx < s; kx++) begin
              int v = img[(oy*s + ky)*w + ox*s + kx];
              sum += v;
              if (v > mx) mx = v;
            end
          case (mode)
            1, 3:    expQ.push_back(mx);
            2, 4:    expQ.push_back(floorDiv(sum, s*s));
            6:       expQ.push_back(img[(oy*s)*w + ox*s + 1]);
            default: expQ.push_back(img[(oy*s)*w + ox*s]);
          endcase
        end
    end
  endtask

  task automatic runFrame(input int mode, input int w, input int h, input int inPct,
                          input int outPct, input int fill);
    int pIdx = 0;
    int nExp, nGot = 0, cycles = 0;
    bit prevValid = 0, prevReady = 0, finished = 0;
    int prevData = 0;
    string rq = reqOf(mode);
    for (int i = 0; i < w*h; i++) begin
      int r = int'($urandom_range(0, 99));
      if (fill == 1)      img[i] = -int'($urandom_range(1, 32768));
      else if (r < 8)     img[i] = -32768;
      else if (r < 16)    img[i] = 32767;
      else                img[i] = int'($urandom_range(0, 65535)) - 32768;
    end
    buildExpected(mode, w, h);
    nExp = expQ.size();
    @(negedge clk);
    start = 1'b1;
    cfgMode = 4'(mode);
    cfgRowWidthM1 = 10'(w - 1);
    cfgColHeightM1 = 9'(h - 1);
    @(negedge clk);
    start = 1'b0;
    // R6: scramble configuration pins while the frame runs
    cfgMode = 4'd3;
    cfgRowWidthM1 = 10'd2;
    cfgColHeightM1 = 9'd7;
    while (!finished) begin
      @(negedge clk);
      cycles++;
      inValid  = (pIdx < w*h) && (int'($urandom_range(0, 99)) < inPct);
      inData   = (pIdx < w*h) ? 16'(img[pIdx]) : 16'sd0;
      outReady = int'($urandom_range(0, 99)) < outPct;
      #1;
      if (prevValid && !prevReady)  // R8 hold
        check(outValid && (int'(outData) == prevData), "R8", int'(outData), prevData);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R5", int'(outData), 0);
        else begin
          int e = expQ.pop_front();
          check(int'(outData) == e, rq, int'(outData), e);
        end
        nGot++;
      end
      if (inValid && inReady) pIdx++;
      if (done) begin
        check(nGot == nExp, "R5", nGot, nExp);
        check(pIdx == w*h, "R9", pIdx, w*h);
        check(!inReady && !outValid, "R9", int'(inReady), 0);
        finished = 1;
      end
      prevValid = outValid;
      prevReady = outReady;
      prevData  = int'(outData);
      if (cycles > 20000) begin
        check(1'b0, "R9", cycles, 20000);
        finished = 1;
      end
    end
    inValid = 1'b0;
    outReady = 1'b0;
    @(negedge clk);
    check(!done, "R9", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid, "R10", int'(outValid), 0);
    check(!inReady,  "R10", int'(inReady), 0);
    check(!done,     "R10", int'(done), 0);
    check(!modeErr,  "R10", int'(modeErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!inReady, "R10", int'(inReady), 0);

    runFrame(0, 5, 3, 70, 60, 0);    // R1
    runFrame(0, 6, 4, 100, 100, 0);  // R1 back to back
    runFrame(1, 6, 5, 100, 100, 0);  // R2 vacate and refill together
    runFrame(2, 7, 6, 80, 50, 1);    // R3 negative floors
    runFrame(3, 9, 8, 90, 40, 0);    // R2 4x4, R5 ragged edge
    runFrame(4, 8, 9, 100, 100, 1);  // R3 4x4
    runFrame(5, 6, 4, 60, 70, 0);    // R4
    runFrame(6, 5, 4, 100, 30, 0);   // R4 top-right, odd width
    runFrame(7, 8, 5, 75, 75, 0);    // R4 4x4 corner
    runFrame(8, 5, 4, 100, 100, 1);  // R3 step 1
    runFrame(9, 4, 6, 50, 90, 0);    // R2 step 1
    runFrame(1, 1, 3, 100, 100, 0);  // R5 no output at all
    runFrame(9, 1, 1, 100, 100, 0);  // R5 single pixel, no output
    runFrame(2, 64, 3, 100, 100, 0); // R5 wide, one incomplete row
    check(!modeErr, "R7", int'(modeErr), 0);
    runFrame(12, 4, 3, 90, 80, 0);   // R7 bypass fallback
    check(modeErr, "R7", int'(modeErr), 1);
    runFrame(2, 4, 4, 90, 80, 0);    // R7 flag stays
    check(modeErr, "R7", int'(modeErr), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule